// File: doc/BRIEF.md
# Segmented Sample-RAM Serial Load Sequencer

This block sits between a four-wire serial port and a 1024-entry, 32-bit sample RAM. It turns a stream of serial bits into whole RAM words on a write, and turns RAM words back into serial bits on a read. The range of addresses that one serial transaction covers comes from one of two segment registers. Each segment register holds its own first and last address.

A dedicated select pin picks the active segment. Only its transitions count, not its level. The pin passes through a two-stage synchronizer, and an edge detector watches the synchronized value. While chip select is inactive, the address counter is preloaded with the first address of the active segment. During a transaction the counter steps upward by one per 32-bit word, and each step is locked to the serial word boundary. When the last address of the segment has been accessed, a done flag rises and the remaining serial traffic has no effect.

The serial signals are sampled in the system clock domain. They are expected to be synchronous to `clk`, and `sclk` runs well below the system clock.

Top module: `seg_ram_loader`

## Requirements
- R1: A write on the config port (`cfg_we` high for one cycle) stores `cfg_start` and `cfg_end` into segment register `cfg_seg` (0 or 1). Writing one segment never alters the other segment.
- R2: A rising edge on `seg_sel` makes segment 1 active and a falling edge makes segment 0 active. Each edge takes effect after a two-flop synchronizer, and a steady level changes nothing. While `csn` is high, `ram_addr` shows the first address of the active segment.
- R3: In write mode (`rd_mode`=0), `sdi` is sampled on each rising `sclk` edge, most significant bit first. In the clock cycle after the 32nd rising edge of a word, `ram_we` is high for exactly one cycle, with the word on `ram_wdata`. `ram_we` and `ram_re` are never high together.
- R4: The first word of a transaction goes to the segment's first address. Each later word goes to the previous address plus one, always counting upward.
- R5: After the word at the segment's last address has been accessed, `done` goes high and stays high until `csn` returns high. While `done` is high, further serial words cause no RAM write and no RAM read, and `sdo` is 0.
- R6: In read mode (`rd_mode`=1), the word at the current address is fetched when `csn` falls and again after each 32nd rising edge. It is shifted out on `sdo` most significant bit first, with each bit valid before the rising `sclk` edge that follows it. The RAM answers a `ram_re` cycle with `ram_rdata` on the next cycle.
- R7: A one-cycle pulse on `srst` while `csn` is low clears the bit count and returns `ram_addr` to the active segment's first address. The next 32 bits then form a complete word for that address.
- R8: Segments may overlap and nothing checks for it. A later transaction overwrites the shared addresses, so the last write to an address wins.
- R9: After reset, `ram_we`, `ram_re` and `done` are 0. Both segments hold first and last address 0, segment 0 is active, and `ram_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_seg | input | 1 | Segment register index for a config write |
| cfg_start | input | 10 | First address to store |
| cfg_end | input | 10 | Last address to store |
| seg_sel | input | 1 | Segment select pin; edges choose the segment |
| sclk | input | 1 | Serial clock |
| csn | input | 1 | Serial chip select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| srst | input | 1 | Serial port reset, active-high pulse |
| rd_mode | input | 1 | 1 = read from RAM, 0 = write to RAM |
| ram_addr | output | 10 | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 32 | RAM write data |
| ram_re | output | 1 | RAM read enable |
| ram_rdata | input | 32 | RAM read data, one cycle after `ram_re` |
| done | output | 1 | Last address of the segment has been accessed |

## Verification
The properties take for granted that `csn`, `sclk`, `sdi`, `srst` and `rd_mode` are synchronous to `clk`. They also assume that each `sclk` level lasts at least two system cycles, so two word boundaries never fall in adjacent cycles. Another assumption is that `rd_mode` is constant while `csn` is low, and that each segment's first address does not exceed its last. The bench changes every input on the falling edge of `clk` and holds each `sclk` level for four cycles. It changes `rd_mode` only while `csn` is high, and it programs only ordered ranges. Edge cases covered are an overlap, a mid-word serial reset, and words sent past the end of a segment.

// File: rtl/seg_ram_pkg.sv
package seg_ram_pkg;
  localparam int unsigned SR_ADDR_W   = 10;
  localparam int unsigned SR_DATA_W   = 32;
  localparam int unsigned SR_NUM_SEGS = 2;
  localparam int unsigned SR_SEG_W    = (SR_NUM_SEGS > 1) ? $clog2(SR_NUM_SEGS) : 1;

  typedef enum logic {
    XFER_WRITE = 1'b0,
    XFER_READ  = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/seg_ram_select.sv
module seg_ram_select (
  input  logic clk,
  input  logic rst_n,
  input  logic seg_sel_i,
  output logic active_o
);
  logic [2:0] sync_q, sync_d;
  logic       act_d;
  logic       sel_rise, sel_fall;

  assign sel_rise = sync_q[1] & ~sync_q[2];
  assign sel_fall = ~sync_q[1] & sync_q[2];

  always_comb begin
    sync_d = {sync_q[1:0], seg_sel_i};
    act_d  = active_o;
    if (sel_rise) begin
      act_d = 1'b1;
    end else if (sel_fall) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      active_o <= 1'b0;
    end else begin
      sync_q   <= sync_d;
      active_o <= act_d;
    end
  end
endmodule

// File: rtl/seg_ram_bank.sv
module seg_ram_bank #(
  parameter int unsigned ADDR_W   = seg_ram_pkg::SR_ADDR_W,
  parameter int unsigned NUM_SEGS = seg_ram_pkg::SR_NUM_SEGS,
  localparam int unsigned SEG_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [SEG_W-1:0]  cfg_seg_i,
  input  logic [ADDR_W-1:0] cfg_start_i,
  input  logic [ADDR_W-1:0] cfg_end_i,
  input  logic [SEG_W-1:0]  sel_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] end_o
);
  logic [ADDR_W-1:0] start_q [NUM_SEGS];
  logic [ADDR_W-1:0] end_q   [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    logic wr_en;
    assign wr_en = cfg_we_i && (cfg_seg_i == SEG_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q[g] <= '0;
        end_q[g]   <= '0;
      end else if (wr_en) begin
        start_q[g] <= cfg_start_i;
        end_q[g]   <= cfg_end_i;
      end
    end
  end

  assign start_o = start_q[sel_i];
  assign end_o   = end_q[sel_i];
endmodule

// File: rtl/seg_ram_shifter.sv
module seg_ram_shifter #(
  parameter int unsigned DATA_W = seg_ram_pkg::SR_DATA_W,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              word_evt_o,
  output logic [DATA_W-1:0] word_data_o,
  output logic              sdo_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-2:0] sin_q, sin_d;
  logic [DATA_W-1:0] sout_q, sout_d;
  logic              skip_q, skip_d;

  assign word_data_o = {sin_q, sdi_i};
  assign word_evt_o  = en_i && rise_i && (cnt_q == CNT_W'(DATA_W - 1));
  assign sdo_o       = sout_q[DATA_W-1];

  always_comb begin
    cnt_d  = cnt_q;
    sin_d  = sin_q;
    sout_d = sout_q;
    skip_d = skip_q;
    if (clr_i) begin
      cnt_d  = '0;
      skip_d = 1'b0;
    end else if (en_i) begin
      if (rise_i) begin
        sin_d = word_data_o[DATA_W-2:0];
        cnt_d = cnt_q + 1'b1;
        if (word_evt_o) begin
          skip_d = 1'b1;
        end
      end
      if (fall_i) begin
        skip_d = 1'b0;
        if (!skip_q) begin
          sout_d = {sout_q[DATA_W-2:0], 1'b0};
        end
      end
    end
    if (load_i) begin
      sout_d = load_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sin_q  <= '0;
      sout_q <= '0;
      skip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sin_q  <= sin_d;
      sout_q <= sout_d;
      skip_q <= skip_d;
    end
  end
endmodule

// File: rtl/seg_ram_addr_ctl.sv
module seg_ram_addr_ctl #(
  parameter int unsigned ADDR_W = seg_ram_pkg::SR_ADDR_W,
  parameter int unsigned DATA_W = seg_ram_pkg::SR_DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_i,
  input  logic                  start_evt_i,
  input  logic                  srst_i,
  input  seg_ram_pkg::xfer_dir_e dir_i,
  input  logic [ADDR_W-1:0]     seg_start_i,
  input  logic [ADDR_W-1:0]     seg_end_i,
  input  logic                  word_evt_i,
  input  logic [DATA_W-1:0]     word_data_i,
  output logic [ADDR_W-1:0]     addr_o,
  output logic                  we_o,
  output logic [DATA_W-1:0]     wdata_o,
  output logic                  re_o,
  output logic                  load_o,
  output logic                  done_o
);
  import seg_ram_pkg::*;

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic              we_d, re_d, load_d, done_d;
  logic              adv_q, adv_d;
  logic              is_read, at_end, step;

  assign is_read = (dir_i == XFER_READ);
  assign at_end  = (addr_o == seg_end_i);
  assign step    = we_o | adv_q;

  always_comb begin
    addr_d  = addr_o;
    done_d  = done_o;
    wdata_d = wdata_o;
    we_d    = 1'b0;
    adv_d   = 1'b0;
    re_d    = 1'b0;
    load_d  = re_o;
    if (!en_i) begin
      addr_d = seg_start_i;
      done_d = 1'b0;
      load_d = 1'b0;
    end else if (srst_i) begin
      addr_d = seg_start_i;
      done_d = 1'b0;
      re_d   = is_read;
      load_d = 1'b0;
    end else begin
      if (start_evt_i) begin
        re_d = is_read;
      end
      if (word_evt_i && !done_o) begin
        if (is_read) begin
          adv_d = 1'b1;
        end else begin
          we_d    = 1'b1;
          wdata_d = word_data_i;
        end
      end
      if (step) begin
        if (at_end) begin
          done_d = 1'b1;
        end else begin
          addr_d = addr_o + 1'b1;
          re_d   = adv_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      done_o  <= 1'b0;
      wdata_o <= '0;
      we_o    <= 1'b0;
      adv_q   <= 1'b0;
      re_o    <= 1'b0;
      load_o  <= 1'b0;
    end else begin
      addr_o  <= addr_d;
      done_o  <= done_d;
      wdata_o <= wdata_d;
      we_o    <= we_d;
      adv_q   <= adv_d;
      re_o    <= re_d;
      load_o  <= load_d;
    end
  end
endmodule

// File: rtl/seg_ram_loader.sv
module seg_ram_loader #(
  parameter int unsigned ADDR_W = seg_ram_pkg::SR_ADDR_W,
  parameter int unsigned DATA_W = seg_ram_pkg::SR_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_seg,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic [ADDR_W-1:0] cfg_end,
  input  logic              seg_sel,
  input  logic              sclk,
  input  logic              csn,
  input  logic              sdi,
  output logic              sdo,
  input  logic              srst,
  input  logic              rd_mode,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_re,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              done
);
  import seg_ram_pkg::*;

  localparam int unsigned SEG_W = 1;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              sclk_q, cs_q;
  logic              cs_act, cs_start, sclk_rise, sclk_fall;
  logic              seg_active;
  logic [ADDR_W-1:0] seg_start, seg_end;
  logic              word_evt, load, sh_sdo, sh_clr;
  logic [DATA_W-1:0] word_data;
  xfer_dir_e         dir;

  // reset asserts asynchronously, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_act;
    end
  end

  assign cs_act    = ~csn;
  assign cs_start  = cs_act & ~cs_q;
  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
  assign sh_clr    = ~cs_act | srst;
  assign dir       = rd_mode ? XFER_READ : XFER_WRITE;

  seg_ram_select i_select (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .seg_sel_i (seg_sel),
    .active_o  (seg_active)
  );

  seg_ram_bank #(
    .ADDR_W   (ADDR_W),
    .NUM_SEGS (SR_NUM_SEGS)
  ) i_bank (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cfg_we_i    (cfg_we),
    .cfg_seg_i   (SEG_W'(cfg_seg)),
    .cfg_start_i (cfg_start),
    .cfg_end_i   (cfg_end),
    .sel_i       (SEG_W'(seg_active)),
    .start_o     (seg_start),
    .end_o       (seg_end)
  );

  seg_ram_shifter #(
    .DATA_W (DATA_W)
  ) i_shifter (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_i        (cs_act),
    .clr_i       (sh_clr),
    .rise_i      (sclk_rise),
    .fall_i      (sclk_fall),
    .sdi_i       (sdi),
    .load_i      (load),
    .load_data_i (ram_rdata),
    .word_evt_o  (word_evt),
    .word_data_o (word_data),
    .sdo_o       (sh_sdo)
  );

  seg_ram_addr_ctl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_addr_ctl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_i        (cs_act),
    .start_evt_i (cs_start),
    .srst_i      (srst),
    .dir_i       (dir),
    .seg_start_i (seg_start),
    .seg_end_i   (seg_end),
    .word_evt_i  (word_evt),
    .word_data_i (word_data),
    .addr_o      (ram_addr),
    .we_o        (ram_we),
    .wdata_o     (ram_wdata),
    .re_o        (ram_re),
    .load_o      (load),
    .done_o      (done)
  );

  assign sdo = sh_sdo & ~done;
endmodule

// File: rtl/seg_ram_loader_chk.sv
module seg_ram_loader_chk #(
  parameter int unsigned ADDR_W = seg_ram_pkg::SR_ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csn,
  input logic              srst,
  input logic              rd_mode,
  input logic              ram_we,
  input logic              ram_re,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              done,
  input logic              sdo
);
  p_no_we_re_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));

  p_we_write_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(!rd_mode));

  p_re_read_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |-> $past(rd_mode));

  p_addr_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !done && !csn && !srst) |=>
      (done || (ram_addr == ADDR_W'($past(ram_addr) + 1'b1))));

  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !csn && !srst) |=> done);

  p_done_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    csn |=> !done);

  p_no_write_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ram_we);

  p_sdo_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sdo);
endmodule

bind seg_ram_loader seg_ram_loader_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .csn      (csn),
  .srst     (srst),
  .rd_mode  (rd_mode),
  .ram_we   (ram_we),
  .ram_re   (ram_re),
  .ram_addr (ram_addr),
  .done     (done),
  .sdo      (sdo)
);

// File: tb/test_seg_ram_loader.sv
module test_seg_ram_loader;
  logic        clk, rst_n;
  logic        cfg_we, cfg_seg;
  logic [9:0]  cfg_start, cfg_end;
  logic        seg_sel, sclk, csn, sdi, sdo, srst, rd_mode;
  logic [9:0]  ram_addr;
  logic        ram_we, ram_re, done;
  logic [31:0] ram_wdata, ram_rdata;

  logic [31:0] mem [1024];
  int          wr_count;
  int          n_checks, n_errors;

  seg_ram_loader i_seg_ram_loader (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .seg_sel(seg_sel),
    .sclk(sclk), .csn(csn), .sdi(sdi), .sdo(sdo), .srst(srst),
    .rd_mode(rd_mode), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_re(ram_re), .ram_rdata(ram_rdata),
    .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bench RAM model: one-cycle read latency
  always @(posedge clk) begin
    if (ram_we) begin
      mem[ram_addr] <= ram_wdata;
      wr_count      <= wr_count + 1;
    end
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic s, input logic [9:0] a, input logic [9:0] e);
    cfg_seg = s; cfg_start = a; cfg_end = e; cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
    tick(1);
  endtask

  task automatic sel_to(input logic v);
    seg_sel = v;
    tick(6);
  endtask

  task automatic xfer_begin(input logic rd);
    rd_mode = rd;
    tick(1);
    csn = 1'b0;
    tick(4);
  endtask

  task automatic xfer_end();
    tick(4);
    csn = 1'b1;
    tick(4);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int nbits,
                            output logic [31:0] r);
    r = '0;
    for (int i = 31; i > 31 - nbits; i--) begin
      sdi = w[i];
      tick(2);
      r[i] = sdo;
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      tick(2);
    end
  endtask

  task automatic shift_word(input logic [31:0] w, output logic [31:0] r);
    shift_bits(w, 32, r);
  endtask

  task automatic t_reset();
    chk(ram_addr == 10'd0, "R9 addr", 32'(ram_addr), 32'd0);
    chk(!ram_we && !ram_re, "R9 we/re", {30'd0, ram_we, ram_re}, 32'd0);
    chk(!done, "R9 done", 32'(done), 32'd0);
  endtask

  task automatic t_write_seg0();
    logic [31:0] r;
    int base;
    cfg(1'b0, 10'd10, 10'd12);
    cfg(1'b1, 10'd20, 10'd21);
    chk(ram_addr == 10'd10, "R1 seg0 start", 32'(ram_addr), 32'd10);
    base = wr_count;
    xfer_begin(1'b0);
    shift_word(32'hA5A5_0001, r);
    chk(ram_addr == 10'd11, "R4 addr step", 32'(ram_addr), 32'd11);
    chk(!done, "R5 not done mid", 32'(done), 32'd0);
    shift_word(32'h8000_0002, r);
    shift_word(32'h1234_5678, r);
    chk(done, "R5 done at end", 32'(done), 32'd1);
    shift_word(32'hDEAD_BEEF, r);
    chk(wr_count - base == 3, "R5 extra word ignored", 32'(wr_count - base), 32'd3);
    chk(mem[13] !== 32'hDEAD_BEEF, "R5 no write past end", mem[13], 32'h0);
    chk(done, "R5 done held", 32'(done), 32'd1);
    xfer_end();
    chk(!done, "R5 done cleared", 32'(done), 32'd0);
    chk(mem[10] == 32'hA5A5_0001, "R3 word0", mem[10], 32'hA5A5_0001);
    chk(mem[11] == 32'h8000_0002, "R3 msb first", mem[11], 32'h8000_0002);
    chk(mem[12] == 32'h1234_5678, "R4 word2", mem[12], 32'h1234_5678);
  endtask

  task automatic t_select();
    logic [31:0] r;
    sel_to(1'b1);
    chk(ram_addr == 10'd20, "R2 rise selects seg1", 32'(ram_addr), 32'd20);
    xfer_begin(1'b0);
    shift_word(32'h0BAD_F00D, r);
    shift_word(32'h7777_0000, r);
    chk(done, "R2 seg1 end", 32'(done), 32'd1);
    xfer_end();
    chk(mem[20] == 32'h0BAD_F00D, "R2 seg1 word0", mem[20], 32'h0BAD_F00D);
    chk(mem[21] == 32'h7777_0000, "R2 seg1 word1", mem[21], 32'h7777_0000);
    tick(6);
    chk(ram_addr == 10'd20, "R2 level no effect", 32'(ram_addr), 32'd20);
    sel_to(1'b0);
    chk(ram_addr == 10'd10, "R2 fall selects seg0", 32'(ram_addr), 32'd10);
  endtask

  task automatic t_read();
    logic [31:0] r;
    xfer_begin(1'b1);
    shift_word(32'h0, r);
    chk(r == 32'hA5A5_0001, "R6 read word0", r, 32'hA5A5_0001);
    shift_word(32'h0, r);
    chk(r == 32'h8000_0002, "R6 read word1", r, 32'h8000_0002);
    shift_word(32'h0, r);
    chk(r == 32'h1234_5678, "R6 read word2", r, 32'h1234_5678);
    chk(done, "R5 done after read", 32'(done), 32'd1);
    shift_word(32'h0, r);
    chk(r == 32'h0, "R5 sdo quiet", r, 32'h0);
    xfer_end();
  endtask

  task automatic t_srst();
    logic [31:0] r;
    xfer_begin(1'b0);
    shift_word(32'h1111_2222, r);
    chk(ram_addr == 10'd11, "R7 before srst", 32'(ram_addr), 32'd11);
    shift_bits(32'hFFFF_FFFF, 7, r);
    srst = 1'b1;
    tick(1);
    srst = 1'b0;
    tick(1);
    chk(ram_addr == 10'd10, "R7 addr to start", 32'(ram_addr), 32'd10);
    shift_word(32'h3C3C_5A5A, r);
    xfer_end();
    chk(mem[10] == 32'h3C3C_5A5A, "R7 aligned word", mem[10], 32'h3C3C_5A5A);
  endtask

  task automatic t_overlap();
    logic [31:0] r;
    cfg(1'b1, 10'd11, 10'd13);
    chk(ram_addr == 10'd10, "R1 seg1 write leaves seg0", 32'(ram_addr), 32'd10);
    xfer_begin(1'b0);
    shift_word(32'hAAAA_0000, r);
    shift_word(32'hAAAA_0001, r);
    shift_word(32'hAAAA_0002, r);
    xfer_end();
    sel_to(1'b1);
    chk(ram_addr == 10'd11, "R1 seg1 new start", 32'(ram_addr), 32'd11);
    xfer_begin(1'b0);
    shift_word(32'hDDDD_0000, r);
    shift_word(32'hDDDD_0001, r);
    shift_word(32'hDDDD_0002, r);
    xfer_end();
    chk(mem[10] == 32'hAAAA_0000, "R8 unshared kept", mem[10], 32'hAAAA_0000);
    chk(mem[11] == 32'hDDDD_0000, "R8 last wins 11", mem[11], 32'hDDDD_0000);
    chk(mem[12] == 32'hDDDD_0001, "R8 last wins 12", mem[12], 32'hDDDD_0001);
    chk(mem[13] == 32'hDDDD_0002, "R8 seg1 end", mem[13], 32'hDDDD_0002);
    sel_to(1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    n_checks = 0; n_errors = 0; wr_count = 0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    ram_rdata = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_seg = 1'b0; cfg_start = '0; cfg_end = '0;
    seg_sel = 1'b0; sclk = 1'b0; csn = 1'b1; sdi = 1'b0; srst = 1'b0;
    rd_mode = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_write_seg0();
    t_select();
    t_read();
    t_srst();
    t_overlap();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule